// File: doc/BRIEF.md
# Decode-Resolved Branch Hazard and Forwarding Unit

This block computes every interlock and bypass control for a five-stage in-order pipeline whose equality branches compare their operands in decode rather than in execute. An equality comparator in decode sees operands one or two stages earlier than the ALU would. Hazards that ordinary forwarding hides from an ALU instruction therefore turn into stalls or new bypass paths for a branch. From the register indices and write flags of the decode, execute, memory and writeback stages, the unit produces four things: the two bypass selects for the execute-stage ALU operands, two bypass selects for the branch comparator in decode, a hold signal for the program counter and the fetch/decode register, and a bubble for the decode/execute register.

All control outputs are combinational functions of the stage fields presented in the current cycle. The pipeline registers around the unit make up its only state. The clock and reset inputs serve the embedded property checks only.

Top module: `hz_branch_unit`

## Requirements
- R1: An execute-stage operand select is 2'b10 (take the memory-stage ALU result) when that operand's source index is nonzero, equals the memory-stage destination, and the memory stage writes a register.
- R2: An execute-stage operand select is 2'b01 (take the writeback value) when only the writeback stage matches and writes. When both later stages match, the memory stage wins. With no match the select is 2'b00, and 2'b11 never appears.
- R3: A source index of 0 never produces a bypass, in execute (select 2'b00) or in decode (select 0), even when a writing stage names destination 0.
- R4: A decode comparator select (one each for the first and second branch source) is 1 when that source is nonzero, equals the memory-stage destination, and the memory stage writes a register.
- R5: Any decode instruction, branch or not, stalls when either of its source indices matches the nonzero destination of a load in execute.
- R6: A branch in decode stalls when either source matches the nonzero destination of a register-writing instruction in execute. An ALU producer directly ahead therefore costs exactly one stall cycle, after which the value reaches the comparator through the decode bypass.
- R7: A branch in decode stalls when either source matches the nonzero destination of a load in the memory stage. A load directly ahead of a dependent branch therefore costs exactly two stall cycles.
- R8: Whenever a stall is raised, the PC hold, the fetch/decode hold and the decode/execute bubble are all 1 in the same cycle. With no stall all three are 0.
- R9: A non-branch instruction does not stall for an ALU producer in execute, nor for a load that has reached the memory stage.
- R10: The decode comparator select stays 0 when the memory stage does not write a register, even if the indices match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst_i | input | 1 | Synchronous active-high reset; disables checks |
| id_rs_i | input | AW | First source index of the decode instruction |
| id_rt_i | input | AW | Second source index of the decode instruction |
| id_branch_i | input | 1 | Decode instruction is an equality branch |
| ex_rs_i | input | AW | First source index of the execute instruction |
| ex_rt_i | input | AW | Second source index of the execute instruction |
| ex_dst_i | input | AW | Destination index in execute |
| ex_regwrite_i | input | 1 | Execute instruction writes a register |
| ex_memtoreg_i | input | 1 | Execute instruction is a load |
| mem_dst_i | input | AW | Destination index in memory stage |
| mem_regwrite_i | input | 1 | Memory-stage instruction writes a register |
| mem_memtoreg_i | input | 1 | Memory-stage instruction is a load |
| wb_dst_i | input | AW | Destination index in writeback |
| wb_regwrite_i | input | 1 | Writeback instruction writes a register |
| id_fwd_a_o | output | 1 | Comparator first operand takes memory-stage result |
| id_fwd_b_o | output | 1 | Comparator second operand takes memory-stage result |
| ex_fwd_a_o | output | 2 | Execute first operand select |
| ex_fwd_b_o | output | 2 | Execute second operand select |
| stall_pc_o | output | 1 | Hold the program counter |
| stall_ifid_o | output | 1 | Hold the fetch/decode register |
| flush_idex_o | output | 1 | Load a bubble into decode/execute |

## Verification
The unit holds no state, so any fault shows at the outputs in the same cycle as the stage fields that expose it. A wrong priority or a missing zero-index guard gives a wrong select value right away. A missing branch rule shows as a stall count other than one or two when a producer/branch pair is stepped through consecutive cycles. That can take effect a cycle after the pair first meets, so the bench replays the stage contents cycle by cycle and counts the held cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_ex_forward.sv
module hz_ex_forward
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_dst_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_dst_i,
  input  logic          wb_we_i,
  output logic [1:0]    sel_o
);
  logic src_live, hit_mem, hit_wb;

  assign src_live = (src_i != '0);
  assign hit_mem  = src_live && mem_we_i && (mem_dst_i == src_i);
  assign hit_wb   = src_live && wb_we_i  && (wb_dst_i  == src_i);

  // the memory stage holds the younger value, so it is checked first
  always_comb begin
    if (hit_mem)     sel_o = FWD_MEM;
    else if (hit_wb) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  p_zero_src_r3: assert property (@(posedge clk) disable iff (rst_i)
    (src_i == '0) |-> (sel_o == FWD_RF));
  p_legal_sel_r2: assert property (@(posedge clk) disable iff (rst_i)
    sel_o != 2'b11);
  p_wb_only_r2: assert property (@(posedge clk) disable iff (rst_i)
    (sel_o == FWD_WB) |-> !(mem_we_i && mem_dst_i == src_i));
  p_mem_write_r1: assert property (@(posedge clk) disable iff (rst_i)
    (sel_o == FWD_MEM) |-> mem_we_i);
endmodule

// File: rtl/hz_id_forward.sv
module hz_id_forward #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_dst_i,
  input  logic          mem_we_i,
  output logic          fwd_o
);
  assign fwd_o = (src_i != '0) && mem_we_i && (mem_dst_i == src_i);

  p_needs_write_r10: assert property (@(posedge clk) disable iff (rst_i)
    fwd_o |-> mem_we_i);
  p_zero_src_r3: assert property (@(posedge clk) disable iff (rst_i)
    (src_i == '0) |-> !fwd_o);
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_branch_i,
  input  logic [AW-1:0] ex_dst_i,
  input  logic          ex_regwrite_i,
  input  logic          ex_memtoreg_i,
  input  logic [AW-1:0] mem_dst_i,
  input  logic          mem_memtoreg_i,
  output logic          stall_o
);
  logic reads_ex, reads_mem;
  logic load_use, branch_alu, branch_load;

  assign reads_ex  = (ex_dst_i != '0) &&
                     ((id_rs_i == ex_dst_i) || (id_rt_i == ex_dst_i));
  assign reads_mem = (mem_dst_i != '0) &&
                     ((id_rs_i == mem_dst_i) || (id_rt_i == mem_dst_i));

  assign load_use    = ex_memtoreg_i && reads_ex;
  assign branch_alu  = id_branch_i && ex_regwrite_i && reads_ex;
  assign branch_load = id_branch_i && mem_memtoreg_i && reads_mem;

  assign stall_o = load_use || branch_alu || branch_load;

  p_load_use_r5: assert property (@(posedge clk) disable iff (rst_i)
    (ex_memtoreg_i && ex_dst_i != '0 && ex_dst_i == id_rs_i) |-> stall_o);
  p_branch_load_r7: assert property (@(posedge clk) disable iff (rst_i)
    (id_branch_i && mem_memtoreg_i && mem_dst_i != '0 && mem_dst_i == id_rt_i)
      |-> stall_o);
endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_branch_i,
  input  logic [AW-1:0] ex_rs_i,
  input  logic [AW-1:0] ex_rt_i,
  input  logic [AW-1:0] ex_dst_i,
  input  logic          ex_regwrite_i,
  input  logic          ex_memtoreg_i,
  input  logic [AW-1:0] mem_dst_i,
  input  logic          mem_regwrite_i,
  input  logic          mem_memtoreg_i,
  input  logic [AW-1:0] wb_dst_i,
  input  logic          wb_regwrite_i,
  output logic          id_fwd_a_o,
  output logic          id_fwd_b_o,
  output logic [1:0]    ex_fwd_a_o,
  output logic [1:0]    ex_fwd_b_o,
  output logic          stall_pc_o,
  output logic          stall_ifid_o,
  output logic          flush_idex_o
);
  localparam int NSRC = 2;

  logic [AW-1:0] ex_src [NSRC];
  logic [AW-1:0] id_src [NSRC];
  logic [1:0]    ex_sel [NSRC];
  logic          id_sel [NSRC];
  logic          stall;

  assign ex_src[0] = ex_rs_i;
  assign ex_src[1] = ex_rt_i;
  assign id_src[0] = id_rs_i;
  assign id_src[1] = id_rt_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_ex_forward #(.AW(AW)) u_exf (
      .clk(clk), .rst_i(rst_i), .src_i(ex_src[g]),
      .mem_dst_i(mem_dst_i), .mem_we_i(mem_regwrite_i),
      .wb_dst_i(wb_dst_i), .wb_we_i(wb_regwrite_i),
      .sel_o(ex_sel[g])
    );
    hz_id_forward #(.AW(AW)) u_idf (
      .clk(clk), .rst_i(rst_i), .src_i(id_src[g]),
      .mem_dst_i(mem_dst_i), .mem_we_i(mem_regwrite_i),
      .fwd_o(id_sel[g])
    );
  end

  hz_stall_detect #(.AW(AW)) u_stall (
    .clk(clk), .rst_i(rst_i),
    .id_rs_i(id_rs_i), .id_rt_i(id_rt_i), .id_branch_i(id_branch_i),
    .ex_dst_i(ex_dst_i), .ex_regwrite_i(ex_regwrite_i),
    .ex_memtoreg_i(ex_memtoreg_i),
    .mem_dst_i(mem_dst_i), .mem_memtoreg_i(mem_memtoreg_i),
    .stall_o(stall)
  );

  assign ex_fwd_a_o   = ex_sel[0];
  assign ex_fwd_b_o   = ex_sel[1];
  assign id_fwd_a_o   = id_sel[0];
  assign id_fwd_b_o   = id_sel[1];
  assign stall_pc_o   = stall;
  assign stall_ifid_o = stall;
  assign flush_idex_o = stall;

  p_branch_alu_r6: assert property (@(posedge clk) disable iff (rst_i)
    (id_branch_i && ex_regwrite_i && ex_dst_i != '0 && ex_dst_i == id_rs_i)
      |-> (stall_pc_o && flush_idex_o));
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst_i)
    (!id_branch_i && !ex_memtoreg_i) |-> !stall_pc_o);
endmodule

// File: tb/hz_branch_unit_test.sv
module hz_branch_unit_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic id_br, ex_we, ex_ld, mem_we, mem_ld, wb_we;
  logic id_fa, id_fb, st_pc, st_ifid, fl_idex;
  logic [1:0] ex_fa, ex_fb;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  hz_branch_unit #(.AW(AW)) uut (
    .clk(clk), .rst_i(rst_i),
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_branch_i(id_br),
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_dst_i(ex_dst),
    .ex_regwrite_i(ex_we), .ex_memtoreg_i(ex_ld),
    .mem_dst_i(mem_dst), .mem_regwrite_i(mem_we), .mem_memtoreg_i(mem_ld),
    .wb_dst_i(wb_dst), .wb_regwrite_i(wb_we),
    .id_fwd_a_o(id_fa), .id_fwd_b_o(id_fb),
    .ex_fwd_a_o(ex_fa), .ex_fwd_b_o(ex_fb),
    .stall_pc_o(st_pc), .stall_ifid_o(st_ifid), .flush_idex_o(fl_idex)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    id_rs = 0; id_rt = 0; id_br = 0;
    ex_rs = 0; ex_rt = 0; ex_dst = 0; ex_we = 0; ex_ld = 0;
    mem_dst = 0; mem_we = 0; mem_ld = 0;
    wb_dst = 0; wb_we = 0;
  endtask

  // apply at the falling edge, outputs are combinational, sample 1 ns later
  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic stall_all(input string req, input int exp);
    chk(req, st_pc, exp);
    chk(req, st_ifid, exp);
    chk(req, fl_idex, exp);
  endtask

  task automatic t_reset();
    quiet();
    settle();
    chk("R8 reset", st_pc, 0);
    chk("R2 reset", ex_fa, 0);
  endtask

  task automatic t_ex_forward();
    quiet(); ex_rs = 7; ex_rt = 9; mem_dst = 7; mem_we = 1; wb_dst = 9; wb_we = 1;
    settle();
    chk("R1 mem a", ex_fa, 2); chk("R2 wb b", ex_fb, 1);
    wb_dst = 7; settle();
    chk("R2 mem over wb", ex_fa, 2); chk("R2 no match b", ex_fb, 0);
    mem_we = 0; settle();
    chk("R2 wb when mem idle", ex_fa, 1);
  endtask

  task automatic t_zero_reg();
    quiet(); ex_rs = 0; mem_dst = 0; mem_we = 1; wb_dst = 0; wb_we = 1;
    id_rs = 0; id_br = 1; settle();
    chk("R3 ex zero", ex_fa, 0); chk("R3 id zero", id_fa, 0);
    ex_dst = 0; ex_we = 1; ex_ld = 1; settle();
    stall_all("R3 no stall on r0", 0);
  endtask

  task automatic t_id_forward();
    quiet(); id_br = 1; id_rs = 3; id_rt = 4; mem_dst = 4; mem_we = 1;
    settle();
    chk("R4 id b", id_fb, 1); chk("R4 id a", id_fa, 0);
    stall_all("R4 alu in mem no stall", 0);
    mem_we = 0; settle();
    chk("R10 no write", id_fb, 0);
  endtask

  task automatic t_load_use();
    quiet(); id_rt = 6; ex_dst = 6; ex_we = 1; ex_ld = 1; settle();
    stall_all("R5 load use", 1);
    quiet(); id_rs = 6; ex_dst = 6; ex_we = 1; settle();
    stall_all("R9 alu then nonbranch", 0);
    quiet(); id_rs = 6; mem_dst = 6; mem_we = 1; mem_ld = 1; settle();
    stall_all("R9 load in mem nonbranch", 0);
  endtask

  // ALU producer r5 followed by branch on r5: step stage contents per cycle
  task automatic t_branch_alu();
    int held = 0;
    quiet(); id_br = 1; id_rs = 5; id_rt = 2; ex_dst = 5; ex_we = 1; settle();
    held += st_pc; chk("R6 cycle1 stall", st_pc, 1);
    quiet(); id_br = 1; id_rs = 5; id_rt = 2; mem_dst = 5; mem_we = 1; settle();
    held += st_pc; chk("R6 bypass after stall", id_fa, 1);
    chk("R6 one cycle", held, 1);
  endtask

  task automatic t_branch_load();
    int held = 0;
    quiet(); id_br = 1; id_rs = 1; id_rt = 8; ex_dst = 8; ex_we = 1; ex_ld = 1; settle();
    held += st_pc; stall_all("R8 group", 1);
    quiet(); id_br = 1; id_rs = 1; id_rt = 8; mem_dst = 8; mem_we = 1; mem_ld = 1; settle();
    held += st_pc; chk("R7 load in mem", st_pc, 1);
    quiet(); id_br = 1; id_rs = 1; id_rt = 8; wb_dst = 8; wb_we = 1; settle();
    held += st_pc; chk("R7 released", st_pc, 0);
    chk("R7 two cycles", held, 2);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    quiet();
    repeat (3) @(posedge clk);
    rst_i = 1'b0;
    t_reset();
    t_ex_forward();
    t_zero_reg();
    t_id_forward();
    t_load_use();
    t_branch_alu();
    t_branch_load();
    finish_run();
  end
endmodule